// File: doc/BRIEF.md
# Fetch Bubble Injector for Stall Redistribution

This block sits beside the fetch stage of an in-order core. Data dependences make the dispatch stage stall for single cycles. The block learns where those stalls fall inside each fetch group. It then re-creates them at fetch as one-cycle bubbles. The transparent-latch front end therefore sees fine-grained gaps rather than coarse stalls. The bubbles are taken from fetch slack, so the back end receives work at the same rate it would have consumed it anyway.

Each group has four slots, and each slot is one cycle of fetch. The prediction store is a direct-mapped table indexed by the group address. Every entry keeps a tag, a four-bit stall pattern (one bit per slot) and a two-bit saturating confidence count. The table is trained from the stall pattern observed when each group retires. A fetched group is perturbed only when its entry is confident. At a fixed interval, a confident group is let through with no bubbles. That unperturbed run acts as a probe: its stall count at retirement either confirms the stored pattern or weakens it.

Top module: `gapinj_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fetch_en` is 1 and every table entry is empty.
- R2: A group whose slot-0 fetch misses in the table (entry invalid or tag different) gets no bubble in any of its slots.
- R3: When injection is active for the current group, `fetch_en` is 0 for exactly the one cycle after a fetched slot whose stall bit is set. Bit k of the stall pattern belongs to slot k. A bubble never lasts two cycles.
- R4: Injection is decided at the slot-0 fetch (the fetch PC's two low bits are 0). It is active only on a hit whose confidence is 2 or 3.
- R5: A retirement that misses allocates the entry: tag written, pattern set to the observed pattern, confidence 0, probe flag cleared. A non-probe hit whose observed pattern equals the stored one raises confidence by one, saturating at 3. A non-probe hit with a different pattern replaces the pattern and clears confidence to 0.
- R6: A counter counts slot-0 fetches that hit a confident entry. The PROBE_PERIOD-th such fetch (every 16th by default) injects nothing in any of its slots and marks its entry as probed. The counter then restarts.
- R7: A retirement that hits a probed entry leaves the pattern unchanged and clears the flag. If the observed stall count (number of set bits) is below the stored count, confidence falls by one, saturating at 0. Otherwise it rises by one, saturating at 3.
- R8: The fetch PC is {tag, index, slot} from high bits to low, with a 2-bit slot field and an IDX_W-bit index. A slot fetch that is not slot 0 follows the decision latched at the last slot-0 fetch only if it belongs to the same group; otherwise it gets no bubble.
- R9: While `fetch_en` is 0, `fetch_valid` is ignored. No slot is consumed, no bubble is scheduled and the probe counter does not advance.
- R10: When a fetch lookup and a retirement update touch the same entry in the same cycle, the fetch uses the entry's contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Front end presents a slot fetch this cycle |
| fetch_pc | input | PC_W | Slot address: {tag, index, slot} |
| ret_valid | input | 1 | A group retires this cycle |
| ret_grp | input | PC_W-2 | Retiring group address: {tag, index} |
| ret_stalls | input | 4 | Observed dispatch stall pattern, bit k after slot k |
| fetch_en | output | 1 | Fetch may advance this cycle; 0 marks an injected bubble |

## Verification
The bench builds the block with a 4-entry table (IDX_W = 2) and a probe period of 4. With these values, two tags sharing an index evict each other within a few retirements. The probe interval comes round after a handful of confident groups, so the probe path is reached and retrained several times in a short run. Directed sequences cover allocation, confidence build-up, probe bypass with falling and rising confidence, mid-group entry and same-cycle fetch/retire collisions. A random phase then mixes fetch streams and retirements while a behavioural model predicts `fetch_en` for every cycle.

// File: rtl/gapinj_pkg.sv
package gapinj_pkg;

    localparam int GAP_SLOTS  = 4;
    localparam int GAP_CONF_W = 2;
    localparam int SLOT_W     = $clog2(GAP_SLOTS);

    typedef logic [GAP_SLOTS-1:0]  stall_vec_t;
    typedef logic [GAP_CONF_W-1:0] conf_t;

    localparam conf_t CONF_MAX = '1;
    localparam conf_t CONF_ARM = {1'b1, {(GAP_CONF_W-1){1'b0}}};

    typedef struct packed {
        stall_vec_t vec;
        conf_t      conf;
    } gap_pred_t;

    typedef enum logic [1:0] {
        TRN_ALLOC,
        TRN_PROBE,
        TRN_AGREE,
        TRN_RELEARN
    } trn_kind_t;

    function automatic int unsigned stall_count(stall_vec_t v);
        int unsigned n = 0;
        for (int i = 0; i < GAP_SLOTS; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

    function automatic conf_t conf_inc(conf_t c);
        return (c == CONF_MAX) ? c : c + conf_t'(1);
    endfunction

    function automatic conf_t conf_dec(conf_t c);
        return (c == '0) ? c : c - conf_t'(1);
    endfunction

endpackage

// File: rtl/gapinj_table.sv
module gapinj_table
    import gapinj_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output gap_pred_t        lk_pred,
    input  logic             probe_set,
    input  logic [IDX_W-1:0] probe_idx,
    input  logic             ret_valid,
    input  logic [IDX_W-1:0] ret_idx,
    input  logic [TAG_W-1:0] ret_tag,
    input  stall_vec_t       ret_obs
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] probe_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    gap_pred_t          pred_q [ENTRIES];

    logic      ret_hit;
    gap_pred_t ret_cur;
    gap_pred_t ret_nxt;
    trn_kind_t kind;

    // lookup for the fetch side reads state before any update this cycle
    always_comb begin
        lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_pred = pred_q[lk_idx];
    end

    always_comb begin
        ret_hit = valid_q[ret_idx] && (tag_q[ret_idx] == ret_tag);
        ret_cur = pred_q[ret_idx];
        if (!ret_hit)                 kind = TRN_ALLOC;
        else if (probe_q[ret_idx])    kind = TRN_PROBE;
        else if (ret_obs == ret_cur.vec) kind = TRN_AGREE;
        else                          kind = TRN_RELEARN;

        ret_nxt = ret_cur;
        case (kind)
            TRN_ALLOC, TRN_RELEARN: ret_nxt = '{vec: ret_obs, conf: '0};
            TRN_AGREE:              ret_nxt.conf = conf_inc(ret_cur.conf);
            TRN_PROBE: begin
                if (stall_count(ret_obs) < stall_count(ret_cur.vec))
                    ret_nxt.conf = conf_dec(ret_cur.conf);
                else
                    ret_nxt.conf = conf_inc(ret_cur.conf);
            end
            default: ret_nxt = ret_cur;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            probe_q <= '0;
        end else begin
            if (ret_valid) begin
                valid_q[ret_idx] <= 1'b1;
                probe_q[ret_idx] <= 1'b0;
            end
            if (probe_set) begin
                probe_q[probe_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ret_valid) begin
            tag_q[ret_idx]  <= ret_tag;
            pred_q[ret_idx] <= ret_nxt;
        end
    end

    // R5
    ret_fills_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> valid_q[$past(ret_idx)] && (tag_q[$past(ret_idx)] == $past(ret_tag)));

    // R7
    probe_keeps_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && kind == TRN_PROBE) |=> pred_q[$past(ret_idx)].vec == $past(ret_cur.vec));

    // R6
    probe_on_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (probe_q & ~valid_q) == '0);

endmodule

// File: rtl/gapinj_sched.sv
module gapinj_sched
    import gapinj_pkg::*;
#(
    parameter int GRP_W        = 14,
    parameter int PROBE_PERIOD = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [GRP_W-1:0]  fetch_grp,
    input  logic [SLOT_W-1:0] fetch_slot,
    input  logic              lk_hit,
    input  gap_pred_t         lk_pred,
    output logic              fetch_en,
    output logic              probe_set
);

    localparam int CNT_W = (PROBE_PERIOD > 2) ? $clog2(PROBE_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROBE_PERIOD - 1);

    typedef struct packed {
        logic             live;
        logic [GRP_W-1:0] grp;
        logic             inject;
        stall_vec_t       vec;
    } grp_ctx_t;

    logic             bub_q;
    logic [CNT_W-1:0] cnt_q;
    grp_ctx_t         ctx_q;

    logic fire, start, armed, take_probe, inject_grp, bub_d;

    always_comb begin
        fire       = fetch_valid && fetch_en;
        start      = fire && (fetch_slot == '0);
        armed      = lk_hit && (lk_pred.conf >= CONF_ARM);
        take_probe = start && armed && (cnt_q == CNT_LAST);
        inject_grp = armed && !take_probe;

        if (start)
            bub_d = inject_grp && lk_pred.vec[0];
        else if (fire)
            bub_d = ctx_q.live && (ctx_q.grp == fetch_grp) && ctx_q.inject
                    && ctx_q.vec[fetch_slot];
        else
            bub_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bub_q <= 1'b0;
            cnt_q <= '0;
            ctx_q <= '0;
        end else begin
            bub_q <= bub_d;
            if (start) begin
                ctx_q <= '{live: 1'b1, grp: fetch_grp, inject: inject_grp, vec: lk_pred.vec};
            end
            if (start && armed) begin
                cnt_q <= take_probe ? '0 : cnt_q + CNT_W'(1);
            end
        end
    end

    assign fetch_en  = !bub_q;
    assign probe_set = take_probe;

    // R1
    reset_open_chk: assert property (@(posedge clk) rst |=> fetch_en);

    // R3
    single_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_en |=> fetch_en);

    // R2
    miss_no_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !lk_hit) |=> fetch_en);

    // R4
    weak_no_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        (start && lk_hit && lk_pred.conf < CONF_ARM) |=> fetch_en);

    // R6
    probe_unperturbed_chk: assert property (@(posedge clk) disable iff (rst)
        probe_set |=> fetch_en && (cnt_q == '0));

    // R9
    bubble_freezes_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_en |=> $stable(cnt_q));

endmodule

// File: rtl/gapinj_top.sv
module gapinj_top
    import gapinj_pkg::*;
#(
    parameter int PC_W         = 16,
    parameter int IDX_W        = 6,
    parameter int PROBE_PERIOD = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fetch_valid,
    input  logic [PC_W-1:0]        fetch_pc,
    input  logic                   ret_valid,
    input  logic [PC_W-SLOT_W-1:0] ret_grp,
    input  logic [GAP_SLOTS-1:0]   ret_stalls,
    output logic                   fetch_en
);

    localparam int GRP_W = PC_W - SLOT_W;
    localparam int TAG_W = GRP_W - IDX_W;

    logic [GRP_W-1:0]  f_grp;
    logic [SLOT_W-1:0] f_slot;
    logic              lk_hit;
    gap_pred_t         lk_pred;
    logic              probe_set;

    assign f_grp  = fetch_pc[PC_W-1:SLOT_W];
    assign f_slot = fetch_pc[SLOT_W-1:0];

    gapinj_table #(
        .IDX_W(IDX_W),
        .TAG_W(TAG_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .lk_idx   (f_grp[IDX_W-1:0]),
        .lk_tag   (f_grp[GRP_W-1:IDX_W]),
        .lk_hit   (lk_hit),
        .lk_pred  (lk_pred),
        .probe_set(probe_set),
        .probe_idx(f_grp[IDX_W-1:0]),
        .ret_valid(ret_valid),
        .ret_idx  (ret_grp[IDX_W-1:0]),
        .ret_tag  (ret_grp[GRP_W-1:IDX_W]),
        .ret_obs  (ret_stalls)
    );

    gapinj_sched #(
        .GRP_W       (GRP_W),
        .PROBE_PERIOD(PROBE_PERIOD)
    ) u_sched (
        .clk        (clk),
        .rst        (rst),
        .fetch_valid(fetch_valid),
        .fetch_grp  (f_grp),
        .fetch_slot (f_slot),
        .lk_hit     (lk_hit),
        .lk_pred    (lk_pred),
        .fetch_en   (fetch_en),
        .probe_set  (probe_set)
    );

endmodule

// File: tb/gapinj_top_test.sv
`timescale 1ns/1ps
module gapinj_top_test;

    localparam int PC_W   = 16;
    localparam int IDX_W  = 2;
    localparam int PERIOD = 4;
    localparam int ENT    = 1 << IDX_W;
    localparam real CLK_NS = 20.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic        ret_valid = 1'b0;
    logic [13:0] ret_grp = '0;
    logic [3:0]  ret_stalls = '0;
    logic        fetch_en;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    gapinj_top #(.PC_W(PC_W), .IDX_W(IDX_W), .PROBE_PERIOD(PERIOD)) uut (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .ret_valid(ret_valid), .ret_grp(ret_grp), .ret_stalls(ret_stalls),
        .fetch_en(fetch_en)
    );

    always #(CLK_NS/2) clk = ~clk;

    // behavioural reference
    bit m_val [ENT];
    int m_tag [ENT];
    int m_vec [ENT];
    int m_conf[ENT];
    bit m_prb [ENT];
    int m_cnt = 0;
    bit m_bub = 0;
    bit m_live = 0;
    int m_grp = 0;
    bit m_inj = 0;
    int m_vq = 0;

    function automatic int ones(int v);
        int n = 0;
        for (int i = 0; i < 4; i++) n += (v >> i) & 1;
        return n;
    endfunction

    task automatic model_step();
        bit fire, hit, hi, nb, pset, rhit, inj;
        int grp, slot, idx, tag, ridx, rtag;
        fire = fetch_valid && !m_bub;
        grp  = int'(fetch_pc) >> 2;
        slot = int'(fetch_pc) & 3;
        idx  = grp % ENT;
        tag  = grp / ENT;
        hit  = m_val[idx] && m_tag[idx] == tag;
        hi   = hit && m_conf[idx] >= 2;
        nb = 0; pset = 0; inj = 0;
        if (fire && slot == 0) begin
            if (hi) begin
                if (m_cnt == PERIOD - 1) begin pset = 1; m_cnt = 0; end
                else begin inj = 1; m_cnt++; end
            end
            nb = inj && (m_vec[idx] & 1);
            m_live = 1; m_grp = grp; m_inj = inj; m_vq = m_vec[idx];
        end else if (fire) begin
            nb = m_live && grp == m_grp && m_inj && ((m_vq >> slot) & 1);
        end
        if (ret_valid) begin
            ridx = int'(ret_grp) % ENT;
            rtag = int'(ret_grp) / ENT;
            rhit = m_val[ridx] && m_tag[ridx] == rtag;
            if (!rhit) begin
                m_val[ridx] = 1; m_tag[ridx] = rtag; m_vec[ridx] = int'(ret_stalls);
                m_conf[ridx] = 0;
            end else if (m_prb[ridx]) begin
                if (ones(int'(ret_stalls)) < ones(m_vec[ridx]))
                    m_conf[ridx] = (m_conf[ridx] > 0) ? m_conf[ridx] - 1 : 0;
                else
                    m_conf[ridx] = (m_conf[ridx] < 3) ? m_conf[ridx] + 1 : 3;
            end else if (int'(ret_stalls) == m_vec[ridx]) begin
                m_conf[ridx] = (m_conf[ridx] < 3) ? m_conf[ridx] + 1 : 3;
            end else begin
                m_vec[ridx] = int'(ret_stalls); m_conf[ridx] = 0;
            end
            m_prb[ridx] = 0;
        end
        if (pset) m_prb[idx] = 1;
        m_bub = nb;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENT; i++) begin
                m_val[i] = 0; m_prb[i] = 0; m_tag[i] = 0; m_vec[i] = 0; m_conf[i] = 0;
            end
            m_cnt = 0; m_bub = 0; m_live = 0; m_grp = 0; m_inj = 0; m_vq = 0;
        end else begin
            model_step();
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (fetch_en !== !m_bub) begin
                errors++;
                $display("FAIL %s: fetch_en=%b expected %b at %0t", cur_req, fetch_en, !m_bub, $time);
            end
        end
    end

    function automatic logic [15:0] pc_of(int tag, int idx, int slot);
        return {tag[11:0], idx[1:0], slot[1:0]};
    endfunction

    task automatic drive(input bit fv, input logic [15:0] fpc,
                         input bit rv, input logic [13:0] rg, input logic [3:0] rs);
        @(negedge clk);
        fetch_valid = fv; fetch_pc = fpc;
        ret_valid = rv; ret_grp = rg; ret_stalls = rs;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, '0, 0, '0, '0);
    endtask

    // fetch slots from first_slot to 3, holding fetch_valid through bubbles
    task automatic fetch_from(int tag, int idx, int first_slot);
        int s = first_slot;
        while (s < 4) begin
            drive(1, pc_of(tag, idx, s), 0, '0, '0);
            if (fetch_en) s++;
        end
        idx = idx;
        idle(1);
    endtask

    task automatic retire(int tag, int idx, logic [3:0] v);
        drive(0, '0, 1, pc_of(tag, idx, 0) >> 2, v);
        idle(1);
    endtask

    task automatic expect_en(bit e, string tagstr);
        checks++;
        if (fetch_en !== e) begin
            errors++;
            $display("FAIL %s: fetch_en=%b expected %b", tagstr, fetch_en, e);
        end
    endtask

    initial begin
        // R1: open fetch during and right after reset
        repeat (3) @(negedge clk);
        expect_en(1, "R1 in reset");
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        expect_en(1, "R1 after reset");

        cur_req = "R2 miss";
        fetch_from(1, 0, 0);

        cur_req = "R5 allocate and agree";
        retire(1, 0, 4'b0101);
        retire(1, 0, 4'b0101);
        retire(1, 0, 4'b0101);

        cur_req = "R3 R4 confident injection";
        fetch_from(1, 0, 0);
        fetch_from(1, 0, 0);

        cur_req = "R4 low confidence";
        retire(1, 1, 4'b1111);
        retire(1, 1, 4'b1111);
        fetch_from(1, 1, 0);

        cur_req = "R6 probe bypass";
        fetch_from(1, 0, 0);
        fetch_from(1, 0, 0);

        cur_req = "R7 probe weaker";
        retire(1, 0, 4'b0001);
        fetch_from(1, 0, 0);
        retire(1, 0, 4'b0101);
        for (int k = 0; k < 4; k++) fetch_from(1, 0, 0);
        cur_req = "R7 probe equal";
        retire(1, 0, 4'b0110);
        for (int k = 0; k < 2; k++) fetch_from(1, 0, 0);

        cur_req = "R8 mid-group entry";
        fetch_from(1, 0, 2);
        drive(1, pc_of(1, 0, 0), 0, '0, '0);
        fetch_from(1, 0, 1);
        fetch_from(1, 0, 0);
        fetch_from(1, 1, 1);

        cur_req = "R9 valid during bubble";
        for (int k = 0; k < 6; k++) fetch_from(1, 0, 0);

        cur_req = "R10 same-cycle update";
        retire(1, 0, 4'b0101);
        drive(1, pc_of(1, 0, 0), 1, pc_of(1, 0, 0) >> 2, 4'b1000);
        fetch_from(1, 0, 1);
        fetch_from(1, 0, 0);

        cur_req = "R5 alias replace";
        retire(2, 0, 4'b0011);
        fetch_from(1, 0, 0);
        retire(2, 0, 4'b0011);
        retire(2, 0, 4'b0011);
        fetch_from(2, 0, 0);

        cur_req = "R3 R6 R7 R8 random";
        for (int k = 0; k < 3000; k++) begin
            int tg, ix, sl, rtg, rix;
            logic [3:0] rv;
            tg = 1 + ($urandom % 2); ix = $urandom % ENT; sl = ($urandom % 3 == 0) ? $urandom % 4 : 0;
            rtg = 1 + ($urandom % 2); rix = $urandom % ENT;
            rv = ($urandom % 5 == 0) ? 4'($urandom) : 4'((rtg * 5 + rix * 3) & 15);
            if ($urandom % 3 == 0) drive(1, pc_of(tg, ix, sl), ($urandom % 4 == 0), pc_of(rtg, rix, 0) >> 2, rv);
            else fetch_from(tg, ix, sl);
        end

        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule